// File: doc/BRIEF.md
# Eight-Bit Bidirectional I/O Port with Timer-Clock Takeover

This block is a byte-wide general-purpose I/O port on a simple byte-addressed register bus. It holds two registers: an output value latch and a per-pin direction mask. When a pin's direction bit is set, the pad buffer is enabled and drives the latch bit. When the bit is clear, the pad floats and the pin is an input. Reading the value address returns a per-bit blend. Pins configured as outputs return the latch bit. Pins configured as inputs return the pad level after a two-flop synchronizer.

Two pins can also serve as external clock inputs for two timers that sit outside this block. Pin 6 feeds timer A and pin 4 feeds timer B. Each takeover is enabled by its own select input. While a pin is taken over, its buffer is forced off whatever its direction bit says. The synchronized pad level then goes out on that timer's clock output. When the select is released, the pin returns to ordinary I/O under its direction bit. The latch accepts writes under every configuration, so software can preload output values before it turns pins into outputs.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction mask and the value latch are both 0x00, so `pad_oe` and `pad_out` are 0x00 and every pin is an input.
- R2: The value latch is at byte address 0x03 and the direction mask is at 0x07. A write takes effect at the clock edge where `bus_we` is sampled high. `bus_rdata` is combinational on `bus_addr` in the same cycle.
- R3: For a pin that is not taken over, `pad_oe` bit i equals direction bit i (1 = output, 0 = input).
- R4: Reading address 0x03 returns the latch bit for every pin whose buffer is enabled.
- R5: Reading address 0x03 returns the pad level for every pin whose buffer is disabled. A pad change becomes visible two clock edges after it, and not after one.
- R6: The latch accepts writes whatever the direction mask holds, and `pad_out` always equals the latch.
- R7: While `clksel_a` is 1, pin 6 has `pad_oe[6]` = 0 whatever its direction bit is. Its read-back is the synchronized pad level, and `tclk_a` equals the synchronized pad 6 level.
- R8: While `clksel_b` is 1, pin 4 has `pad_oe[4]` = 0 whatever its direction bit is. Its read-back is the synchronized pad level, and `tclk_b` equals the synchronized pad 4 level.
- R9: With its select at 0, a timer clock output is 0 and the pin again follows its direction bit.
- R10: Any address other than 0x03 and 0x07 reads as 0x00, and writes to it change neither register.
- R11: Reading address 0x07 returns the direction mask as written, including the bits of pins that are currently taken over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on bus_addr |
| pad_in | input | 8 | Pad levels seen from outside |
| pad_out | output | 8 | Value driven onto the pads |
| pad_oe | output | 8 | Pad buffer enables, 1 = driving |
| clksel_a | input | 1 | Take pin 6 over as timer A clock |
| clksel_b | input | 1 | Take pin 4 over as timer B clock |
| tclk_a | output | 1 | Synchronized pin 6 level for timer A |
| tclk_b | output | 1 | Synchronized pin 4 level for timer B |

## Verification
A direction write and a takeover select can act on the same pin in the same cycle. The bench provokes this by raising `clksel_a` in the cycle in which 0xFF is written to the direction mask. It then judges at the ports: after the edge, `pad_oe` must read 0xBF while the direction read-back shows 0xFF. When the select is dropped, the enable for pin 6 must return at once. The bench also checks that, before the edge, the buffer enables still show the old mask.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Which register a bus address selects
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_DATA = 2'd1,
        ACC_DIR  = 2'd2
    } acc_e;

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int                WIDTH    = 8,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] DATA_OFS = 8'h03,
    parameter logic [ADDR_W-1:0] DIR_OFS  = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    output acc_e              acc,
    output logic [WIDTH-1:0]  latch_q,
    output logic [WIDTH-1:0]  dir_q
);

    typedef struct packed {
        logic [WIDTH-1:0] latch;
        logic [WIDTH-1:0] dir;
    } regs_t;

    regs_t r_d, r_q;
    acc_e  acc_d;

    always_comb begin
        if (bus_addr == DATA_OFS)     acc_d = ACC_DATA;
        else if (bus_addr == DIR_OFS) acc_d = ACC_DIR;
        else                          acc_d = ACC_NONE;

        r_d = r_q;
        if (bus_we) begin
            unique case (acc_d)
                ACC_DATA: r_d.latch = bus_wdata;
                ACC_DIR:  r_d.dir   = bus_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign acc     = acc_d;
    assign latch_q = r_q.latch;
    assign dir_q   = r_q.dir;

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] st;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.st[0] = async_in;
        for (int k = 1; k < STAGES; k++) begin
            s_d.st[k] = s_q.st[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.st[STAGES-1];

endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
    import gpio_port_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int TCLK_A_PIN = 6,
    parameter int TCLK_B_PIN = 4
) (
    input  acc_e             acc,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] pin_sync,
    input  logic             clksel_a,
    input  logic             clksel_b,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] rdata,
    output logic             tclk_a,
    output logic             tclk_b
);

    logic [WIDTH-1:0] takeover;

    // Per-pin takeover mask: only the two timer-clock pins can be claimed
    for (genvar i = 0; i < WIDTH; i++) begin : g_take
        if (i == TCLK_A_PIN && i == TCLK_B_PIN) begin : g_both
            assign takeover[i] = clksel_a | clksel_b;
        end else if (i == TCLK_A_PIN) begin : g_a
            assign takeover[i] = clksel_a;
        end else if (i == TCLK_B_PIN) begin : g_b
            assign takeover[i] = clksel_b;
        end else begin : g_none
            assign takeover[i] = 1'b0;
        end
    end

    always_comb begin
        pad_oe  = dir_q & ~takeover;
        pad_out = latch_q;
        unique case (acc)
            ACC_DATA: rdata = (latch_q & pad_oe) | (pin_sync & ~pad_oe);
            ACC_DIR:  rdata = dir_q;
            default:  rdata = '0;
        endcase
        tclk_a = clksel_a & pin_sync[TCLK_A_PIN];
        tclk_b = clksel_b & pin_sync[TCLK_B_PIN];
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int                WIDTH       = 8,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] DATA_OFS    = 8'h03,
    parameter logic [ADDR_W-1:0] DIR_OFS     = 8'h07,
    parameter int                TCLK_A_PIN  = 6,
    parameter int                TCLK_B_PIN  = 4,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    input  logic              clksel_a,
    input  logic              clksel_b,
    output logic              tclk_a,
    output logic              tclk_b
);

    acc_e             acc;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pin_sync;

    gpio_regs #(
        .WIDTH   (WIDTH),
        .ADDR_W  (ADDR_W),
        .DATA_OFS(DATA_OFS),
        .DIR_OFS (DIR_OFS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .acc      (acc),
        .latch_q  (latch_q),
        .dir_q    (dir_q)
    );

    gpio_sync #(
        .WIDTH (WIDTH),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pad_in),
        .sync_out(pin_sync)
    );

    gpio_pinmux #(
        .WIDTH     (WIDTH),
        .TCLK_A_PIN(TCLK_A_PIN),
        .TCLK_B_PIN(TCLK_B_PIN)
    ) u_mux (
        .acc     (acc),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .pin_sync(pin_sync),
        .clksel_a(clksel_a),
        .clksel_b(clksel_b),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .rdata   (bus_rdata),
        .tclk_a  (tclk_a),
        .tclk_b  (tclk_b)
    );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int                WIDTH      = 8,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] DATA_OFS   = 8'h03,
    parameter logic [ADDR_W-1:0] DIR_OFS    = 8'h07,
    parameter int                TCLK_A_PIN = 6,
    parameter int                TCLK_B_PIN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  pad_out,
    input logic [WIDTH-1:0]  pad_oe,
    input logic              clksel_a,
    input logic              clksel_b,
    input logic              tclk_a,
    input logic              tclk_b
);

    logic [WIDTH-1:0] claim;
    logic             miss;

    always_comb begin
        claim = '0;
        claim[TCLK_A_PIN] = clksel_a;
        claim[TCLK_B_PIN] = claim[TCLK_B_PIN] | clksel_b;
        miss = (bus_addr != DATA_OFS) && (bus_addr != DIR_OFS);
    end

    // R3: a direction write shows on the enables of unclaimed pins
    a_r3_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == DIR_OFS) |=> ((pad_oe | claim) == ($past(bus_wdata) | claim)));

    // R6: latch writes land on the pads whatever the direction
    a_r6_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == DATA_OFS) |=> (pad_out == $past(bus_wdata)));

    // R4: driven pins read back the latch
    a_r4_out_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == DATA_OFS) |-> (((bus_rdata ^ pad_out) & pad_oe) == '0));

    // R7: claimed pin A never drives
    a_r7_pin_a_off: assert property (@(posedge clk) disable iff (!rst_n)
        clksel_a |-> !pad_oe[TCLK_A_PIN]);

    // R8: claimed pin B never drives
    a_r8_pin_b_off: assert property (@(posedge clk) disable iff (!rst_n)
        clksel_b |-> !pad_oe[TCLK_B_PIN]);

    // R9: unselected timer clocks stay low
    a_r9_tclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clksel_a |-> !tclk_a) and (!clksel_b |-> !tclk_b));

    // R10: undecoded addresses read zero and writes there leave the latch alone
    a_r10_miss_read: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (bus_rdata == '0));

    a_r10_miss_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && miss) |=> $stable(pad_out));

endmodule

bind gpio_port gpio_port_chk #(
    .WIDTH     (WIDTH),
    .ADDR_W    (ADDR_W),
    .DATA_OFS  (DATA_OFS),
    .DIR_OFS   (DIR_OFS),
    .TCLK_A_PIN(TCLK_A_PIN),
    .TCLK_B_PIN(TCLK_B_PIN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .clksel_a (clksel_a),
    .clksel_b (clksel_b),
    .tclk_a   (tclk_a),
    .tclk_b   (tclk_b)
);

// File: tb/gpio_port_bench.sv
module gpio_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_DATA = 8'h03;
    localparam logic [7:0] A_DIR  = 8'h07;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'hA5;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic       clksel_a = 1'b0;
    logic       clksel_b = 1'b0;
    logic       tclk_a;
    logic       tclk_b;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port u_gpio_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .clksel_a (clksel_a),
        .clksel_b (clksel_b),
        .tclk_a   (tclk_a),
        .tclk_b   (tclk_b)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic wait_sync();
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        rd_check("R1 dir read", A_DIR, 8'h00);
        rd_check("R5 input read after reset", A_DATA, 8'hA5);
    endtask

    task automatic t_dir_out();
        wr(A_DATA, 8'h3C);
        wr(A_DIR, 8'hF0);
        check("R3 oe follows dir", pad_oe, 8'hF0);
        check("R6 pad_out", pad_out, 8'h3C);
        rd_check("R4 mixed read", A_DATA, 8'h35);
        rd_check("R11 dir read", A_DIR, 8'hF0);
    endtask

    task automatic t_preload();
        wr(A_DIR, 8'h00);
        wr(A_DATA, 8'h5A);
        check("R6 preload pad_out", pad_out, 8'h5A);
        check("R6 preload oe off", pad_oe, 8'h00);
        rd_check("R5 all inputs", A_DATA, 8'hA5);
        wr(A_DIR, 8'hFF);
        rd_check("R4 all outputs", A_DATA, 8'h5A);
    endtask

    task automatic t_sync_lag();
        wr(A_DIR, 8'h00);
        bus_addr = A_DATA;
        @(negedge clk);
        pad_in = 8'h00;
        @(negedge clk);
        #1;
        check("R5 one edge still old", bus_rdata, 8'hA5);
        @(negedge clk);
        #1;
        check("R5 two edges new", bus_rdata, 8'h00);
    endtask

    task automatic t_takeover();
        wr(A_DATA, 8'hFF);
        wr(A_DIR, 8'hFF);
        @(negedge clk);
        clksel_a = 1'b1;
        #1;
        check("R7 pin6 oe off", pad_oe, 8'hBF);
        rd_check("R7 pin6 reads pad", A_DATA, 8'hBF);
        check("R7 tclk_a low", {7'd0, tclk_a}, 8'h00);
        pad_in = 8'h40;
        wait_sync();
        check("R7 tclk_a high", {7'd0, tclk_a}, 8'h01);
        rd_check("R7 pin6 pad high", A_DATA, 8'hFF);
        clksel_b = 1'b1;
        #1;
        check("R8 pin4 oe off", pad_oe, 8'hAF);
        rd_check("R8 pin4 reads pad", A_DATA, 8'hEF);
        pad_in = 8'h50;
        wait_sync();
        check("R8 tclk_b high", {7'd0, tclk_b}, 8'h01);
        rd_check("R11 dir read under takeover", A_DIR, 8'hFF);
        clksel_a = 1'b0;
        clksel_b = 1'b0;
        #1;
        check("R9 oe restored", pad_oe, 8'hFF);
        check("R9 timer clocks low", {6'd0, tclk_a, tclk_b}, 8'h00);
    endtask

    task automatic t_same_cycle();
        wr(A_DIR, 8'h00);
        @(negedge clk);
        bus_addr = A_DIR; bus_we = 1'b1; bus_wdata = 8'hFF;
        clksel_a = 1'b1;
        #1;
        check("R2 write not yet visible", pad_oe, 8'h00);
        @(negedge clk);
        bus_we = 1'b0;
        #1;
        check("R3 R7 same-cycle select and dir write", pad_oe, 8'hBF);
        rd_check("R11 dir holds written value", A_DIR, 8'hFF);
        clksel_a = 1'b0;
        #1;
        check("R9 pin6 follows dir again", pad_oe, 8'hFF);
    endtask

    task automatic t_undecoded();
        wr(8'h05, 8'h00);
        wr(8'h13, 8'h00);
        check("R10 latch unchanged", pad_out, 8'hFF);
        check("R10 dir unchanged", pad_oe, 8'hFF);
        rd_check("R10 read 0x05", 8'h05, 8'h00);
        rd_check("R10 read 0x13", 8'h13, 8'h00);
        rd_check("R2 data address read", A_DATA, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        t_dir_out();
        t_preload();
        t_sync_lag();
        t_takeover();
        t_same_cycle();
        t_undecoded();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule